// File: doc/BRIEF.md
# DRAM Mode Register Read Engine

This block fetches one mode register from an attached low-power DRAM device on request. Software writes a single command register with a device select and an 8-bit mode-register address. The engine then sends one read command on a simple command bus and waits for the device's response. It places the returned byte in the data field of that same command register and raises a data-valid flag, which also drives an interrupt line.

Software clears the data-valid flag before it issues each request. The flag stays low until the new byte has been captured, so a stale result is never mistaken for a fresh one. A read that receives no answer within a programmable number of cycles ends with a timeout flag instead. Command writes that arrive while the engine is busy, or that carry a malformed select, are dropped.

The register file has three words, chosen by a 2-bit index:
- 0 is the command/result register.
- 1 is the status register.
- 2 is the timeout limit.

Top module: `mrr_engine`

## Requirements
- R1: After reset, the command register reads 0, the status register reads 0, the limit register reads the default of 64, `cmd_valid` is low and `irq_o` is low.
- R2: The command register holds the device select in bits 31:30 and the mode-register address in bits 23:16, and returns the result in bits 15:0. Select value 2'b10 addresses device 0 and 2'b01 addresses device 1. A command write with select 2'b00 or 2'b11 is ignored and leaves every register unchanged.
- R3: Each accepted command write produces exactly one `cmd_valid` pulse, in the cycle after the write. During that pulse `cmd_cs_n` equals the written select and `cmd_ma` equals the written address. While `cmd_valid` is low, `cmd_cs_n` reads 2'b11.
- R4: The result field is cleared to 0 when a command is accepted. On a response, bits 7:0 take `resp_data[7:0]` and bits 15:8 read 0.
- R5: Status bit 5 (data-valid) stays 0 while a read is in flight. It is set on the clock edge that captures the response. `irq_o` follows status bit 5.
- R6: Writing 1 to status bit 5 or bit 1 clears that bit, and writing 0 leaves it unchanged. Status bit 0 cannot be changed by a write.
- R7: Status bit 0 (busy) is 1 from the edge that accepts a command until the read completes or times out. A command write while busy is ignored.
- R8: The limit register (index 2, 16 bits) sets how many cycles the engine waits. A response that arrives in waiting cycle N, with N at most the limit, is captured. If no response arrives by the end of the last allowed cycle, status bit 1 (timeout) is set and busy drops. Data-valid is not set and the result field stays 0.
- R9: A response that arrives while the engine is not waiting is ignored, including one that arrives after a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index for the write |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register index for the read |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Data-valid interrupt |
| cmd_valid | output | 1 | Mode-register read command strobe |
| cmd_cs_n | output | 2 | Active-low per-device select |
| cmd_ma | output | 8 | Mode-register address |
| resp_valid | input | 1 | Device response strobe |
| resp_data | input | 16 | Device response data |

## Verification
The assertions assume the device side behaves in a specific way. It raises `resp_valid` only as a single-cycle strobe, and its response carries no meaning outside the engine's wait window. The assertions also assume that software clears the data-valid flag before each request, so a rising interrupt always marks the end of a read.

The bench's responder answers only after it has seen a command pulse, and it answers once per command. Software always clears the flags before issuing a command. The only responses the bench sends outside a wait are deliberate ones: an unsolicited pulse while the engine is idle, and a late answer after a timeout. Both are used to check that such responses are ignored.

// File: rtl/mrr_engine.sv
module mrr_engine #(
  parameter int TO_W     = 16,
  parameter int TO_RESET = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq_o,
  output logic        cmd_valid,
  output logic [1:0]  cmd_cs_n,
  output logic [7:0]  cmd_ma,
  input  logic        resp_valid,
  input  logic [15:0] resp_data
);
  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_LIM  = 2'd2;
  localparam int PAD_W = 32 - TO_W;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t st_q;
  logic [1:0] sel_q;
  logic [7:0] ma_q, dat_q;
  logic dv_q, to_q;
  logic [TO_W-1:0] lim_q, cnt_q;

  wire busy   = (st_q != S_IDLE);
  wire cmd_wr = wr_en && (wr_addr == A_CMD);
  wire st_wr  = wr_en && (wr_addr == A_STAT);
  wire lim_wr = wr_en && (wr_addr == A_LIM);
  wire accept = cmd_wr && !busy && (^wr_data[31:30]);
  wire waiting = (st_q == S_WAIT);
  wire got    = waiting && resp_valid;
  wire expire = waiting && !resp_valid &&
                (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_q});

  wire unused_bits = ^{wr_data[29:24], wr_data[15:6], wr_data[4:2],
                       wr_data[0], wr_data[31:16], resp_data[15:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sel_q <= 2'b00;
      ma_q  <= 8'h00;
      dat_q <= 8'h00;
      cnt_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          sel_q <= wr_data[31:30];
          ma_q  <= wr_data[23:16];
          dat_q <= 8'h00;
          st_q  <= S_ISSUE;
        end
        S_ISSUE: begin
          cnt_q <= '0;
          st_q  <= S_WAIT;
        end
        S_WAIT: begin
          if (got) begin
            dat_q <= resp_data[7:0];
            st_q  <= S_IDLE;
          end else if (expire) begin
            st_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      to_q  <= 1'b0;
      lim_q <= TO_W'(TO_RESET);
    end else begin
      if (got)                      dv_q <= 1'b1;
      else if (st_wr && wr_data[5]) dv_q <= 1'b0;
      if (expire)                   to_q <= 1'b1;
      else if (st_wr && wr_data[1]) to_q <= 1'b0;
      if (lim_wr) lim_q <= wr_data[TO_W-1:0];
    end
  end

  always_comb begin
    case (rd_addr)
      A_CMD:   rd_data = {sel_q, 6'b0, ma_q, 8'b0, dat_q};
      A_STAT:  rd_data = {26'b0, dv_q, 3'b0, to_q, busy};
      A_LIM:   rd_data = {{PAD_W{1'b0}}, lim_q};
      default: rd_data = 32'h0;
    endcase
  end

  assign irq_o     = dv_q;
  assign cmd_valid = (st_q == S_ISSUE);
  assign cmd_cs_n  = cmd_valid ? sel_q : 2'b11;
  assign cmd_ma    = ma_q;
endmodule

// File: rtl/mrr_engine_chk.sv
module mrr_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_cs_n,
  input logic       resp_valid,
  input logic       irq_o,
  input logic       busy,
  input logic       to_flag
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r3_cs_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_cs_n == 2'b10 || cmd_cs_n == 2'b01));
  a_r3_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> cmd_cs_n == 2'b11);
  a_r7_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> busy);
  a_r5_irq_needs_resp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(resp_valid));
  a_r5_irq_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $fell(busy));
  a_r8_timeout_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> ($fell(busy) && !$rose(irq_o)));
endmodule

bind mrr_engine mrr_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cs_n(cmd_cs_n),
  .resp_valid(resp_valid), .irq_o(irq_o), .busy(busy), .to_flag(to_q)
);

// File: tb/tb_mrr_engine.sv
module tb_mrr_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [31:0] wr_data = 32'h0, rd_data;
  logic irq_o, cmd_valid;
  logic [1:0] cmd_cs_n;
  logic [7:0] cmd_ma;
  logic resp_valid = 1'b0;
  logic [15:0] resp_data = 16'h0;

  always #5 clk = ~clk;

  mrr_engine dut (.*);

  typedef struct {
    bit run;
    logic [31:0] exp_cmd;
    bit exp_dv, exp_to, late;
    logic [31:0] exp_lim;
    int exp_pulses;
    logic [1:0] cs;
    logic [7:0] ma;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0, push_cnt = 0, done_cnt = 0, exp_pulses = 0;
  int pulse_cnt = 0, lat = 3, pend = 0;
  bit resp_en = 1'b1, finished = 1'b0;
  logic [1:0] last_cs = 2'b11;
  logic [7:0] last_ma = 8'h0;
  logic [31:0] lim_now = 32'd64;
  logic [31:0] cmd_now = 32'h0;
  bit dv_now = 1'b0, to_now = 1'b0;

  function automatic logic [7:0] key(logic [1:0] cs, logic [7:0] ma);
    return ma ^ ((cs == 2'b10) ? 8'h3C : 8'hC3);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // responder
  initial forever begin
    @(negedge clk);
    resp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        resp_valid = 1'b1;
        resp_data  = {8'h5A, key(last_cs, last_ma)};
      end
    end
    if (cmd_valid) begin
      pulse_cnt++;
      last_cs = cmd_cs_n;
      last_ma = cmd_ma;
      if (resp_en) pend = lat;
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(item_t it);
    q.push_back(it);
    push_cnt++;
  endtask

  task automatic expect_still(string tag);
    item_t it;
    it.run = 0; it.exp_cmd = cmd_now; it.exp_dv = dv_now; it.exp_to = to_now;
    it.late = 0; it.exp_lim = lim_now; it.exp_pulses = exp_pulses;
    it.cs = 2'b11; it.ma = 8'h0; it.tag = tag;
    push(it);
    wait (done_cnt == push_cnt);
  endtask

  task automatic do_read(logic [1:0] cs, logic [7:0] ma, bit ok, bit busy_wr, string tag);
    item_t it;
    wr(2'd1, 32'h22);
    dv_now = 0; to_now = 0;
    wr(2'd0, {cs, 6'b0, ma, 16'h0});
    exp_pulses++;
    cmd_now = {cs, 6'b0, ma, 8'b0, ok ? key(cs, ma) : 8'h00};
    dv_now = ok; to_now = !ok;
    it.run = 1; it.exp_cmd = cmd_now; it.exp_dv = ok; it.exp_to = !ok;
    it.late = !ok && resp_en; it.exp_lim = lim_now; it.exp_pulses = exp_pulses;
    it.cs = cs; it.ma = ma; it.tag = tag;
    push(it);
    if (busy_wr) wr(2'd0, {2'b01, 6'b0, 8'h11, 16'h0});
    wait (done_cnt == push_cnt);
  endtask

  task automatic check_regs(item_t it);
    rd_addr = 2'd0; #1;
    chk({it.tag, " cmd"}, rd_data, it.exp_cmd);
    rd_addr = 2'd1; #1;
    chk({it.tag, " stat"}, rd_data, {26'b0, it.exp_dv, 3'b0, it.exp_to, 1'b0});
    chk({it.tag, " irq R5"}, {31'b0, irq_o}, {31'b0, it.exp_dv});
    rd_addr = 2'd2; #1;
    chk({it.tag, " lim R8"}, rd_data, it.exp_lim);
    chk({it.tag, " pulses R3"}, pulse_cnt, it.exp_pulses);
  endtask

  // monitor
  initial begin
    item_t it;
    wait (rst_n);
    @(negedge clk);
    rd_addr = 2'd0; #1; chk("R1 cmd reset", rd_data, 32'h0);
    rd_addr = 2'd1; #1; chk("R1 stat reset", rd_data, 32'h0);
    rd_addr = 2'd2; #1; chk("R1 lim reset", rd_data, 32'd64);
    chk("R1 outputs reset", {29'b0, cmd_valid, irq_o, cmd_cs_n == 2'b11}, 32'h1);
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      if (it.run) begin
        @(negedge clk);
        rd_addr = 2'd1; #1;
        chk({it.tag, " R7 busy"}, {31'b0, rd_data[0]}, 32'h1);
        chk({it.tag, " R5 dv low in flight"}, {31'b0, rd_data[5]}, 32'h0);
        while (rd_data[0]) begin
          @(negedge clk); rd_addr = 2'd1; #1;
        end
        check_regs(it);
        chk({it.tag, " R3 cs"}, {30'b0, last_cs}, {30'b0, it.cs});
        chk({it.tag, " R3 ma"}, {24'b0, last_ma}, {24'b0, it.ma});
        if (it.late) begin
          repeat (4) @(negedge clk);
          it.tag = {it.tag, " R9 late"};
          check_regs(it);
        end
      end else begin
        repeat (3) @(negedge clk);
        check_regs(it);
      end
      done_cnt++;
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    do_read(2'b10, 8'h05, 1, 0, "R2 R4 dev0 ma05");
    do_read(2'b01, 8'h08, 1, 0, "R2 R4 dev1 ma08");
    do_read(2'b10, 8'hFF, 1, 1, "R7 busy write ignored");
    wr(2'd0, {2'b00, 6'b0, 8'h77, 16'h0});
    expect_still("R2 select 00 ignored");
    wr(2'd0, {2'b11, 6'b0, 8'h66, 16'h0});
    expect_still("R2 select 11 ignored");
    wr(2'd1, 32'h01);
    expect_still("R6 write busy bit no effect");
    wr(2'd1, 32'h20);
    dv_now = 0;
    expect_still("R6 dv cleared");
    @(negedge clk);
    resp_valid = 1'b1; resp_data = 16'hFFFF;
    expect_still("R9 idle response ignored");
    wr(2'd2, 32'd4); lim_now = 32'd4; lat = 4;
    do_read(2'b01, 8'h33, 1, 0, "R8 response at limit");
    wr(2'd2, 32'd3); lim_now = 32'd3;
    do_read(2'b10, 8'h44, 0, 0, "R8 timeout one short");
    resp_en = 1'b0; wr(2'd2, 32'd6); lim_now = 32'd6;
    do_read(2'b01, 8'h55, 0, 0, "R8 timeout no response");
    wr(2'd1, 32'h02);
    to_now = 0;
    expect_still("R6 timeout cleared");
    resp_en = 1'b1; lat = 2; wr(2'd2, 32'd64); lim_now = 32'd64;
    do_read(2'b01, 8'h20, 1, 0, "R4 recovery after timeout");
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule